// File: doc/BRIEF.md
# Store Queue with Read Bypass

This block is a small first-in, first-out store queue placed between a write-through cache and a slow main memory. Each processor store is written into the cache and, in the same cycle, handed to the queue as an address and data pair. A memory-side port presents the oldest queued entry, and memory takes entries one at a time in arrival order. A second enqueue port accepts a dirty line evicted by a write-back cache. This lets a pending read miss go to memory first, with the eviction write following behind it.

When a read miss is presented, every occupied slot is compared against the read address in the same cycle. With no match, the read is cleared to use memory at once, ahead of the queued writes, and draining pauses for that cycle. With a match, the parameter `FWD_EN` sets the response. In forwarding mode the data of the youngest matching entry is returned and the entry stays queued. In holding mode the read is told to wait, and draining continues until the conflicting entry has left.

If stores arrive faster than memory can absorb them, the queue fills whatever its depth. Acceptance is then withdrawn until an entry drains.

Top module: `wrbuf_rdprio`

## Requirements
- R1: After reset the queue is empty. `mem_wr_valid` is 0, `st_ready` and `vic_ready` are 1, and any read is cleared to memory (`rd_mem_go`=1).
- R2: Entries reach the memory port in arrival order. `mem_wr_addr`/`mem_wr_data` show the oldest entry, and one entry leaves on each cycle with `mem_wr_valid` and `mem_wr_ready` both high.
- R3: The queue holds `DEPTH` entries (default 4). When it holds `DEPTH`, both `st_ready` and `vic_ready` are 0, and a store offered then is not queued.
- R4: An accepted enqueue and a drain in the same cycle leave the number of queued entries unchanged.
- R5: A read whose address matches no queued entry raises `rd_mem_go` in the same cycle. `mem_wr_valid` is 0 in that cycle, and no entry leaves.
- R6: With `FWD_EN`=1, a read matching one or more queued entries raises `rd_fwd`. `rd_fwd_data` carries the data of the most recently queued match, and the queue contents are unchanged.
- R7: With `FWD_EN`=0, a matching read raises `rd_hold` while draining continues. Once no matching entry remains, the same read gets `rd_mem_go`.
- R8: When `vic_valid` and `st_valid` are both high, the eviction is queued and `st_ready` is 0 in that cycle.
- R9: While `rd_valid` is high, exactly one of `rd_mem_go`, `rd_fwd` and `rd_hold` is high. While `rd_valid` is low, none is high.
- R10: While `mem_wr_valid` is high and `mem_wr_ready` is low, the presented address and data do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | Processor store offered |
| st_addr | input | 16 | Store address |
| st_data | input | 32 | Store data |
| st_ready | output | 1 | Store accepted this cycle when high |
| vic_valid | input | 1 | Evicted dirty line offered |
| vic_addr | input | 16 | Eviction address |
| vic_data | input | 32 | Eviction data |
| vic_ready | output | 1 | Eviction accepted this cycle when high |
| rd_valid | input | 1 | Read miss presented for lookup |
| rd_addr | input | 16 | Read miss address |
| rd_mem_go | output | 1 | Read may use memory now |
| rd_fwd | output | 1 | Read satisfied from the queue |
| rd_fwd_data | output | 32 | Forwarded data |
| rd_hold | output | 1 | Read must wait for a conflicting write |
| mem_wr_valid | output | 1 | Oldest entry presented to memory |
| mem_wr_addr | output | 16 | Oldest entry address |
| mem_wr_data | output | 32 | Oldest entry data |
| mem_wr_ready | input | 1 | Memory takes the presented entry |

## Verification
A wrong pointer or occupancy count shows up at the memory port within one drain cycle, as an entry out of order, a repeated entry, or a `mem_wr_valid` that disagrees with the number of queued stores. It also moves the cycle at which `st_ready` falls, which is visible on the very enqueue that should have filled the queue. A fault in the slot comparison or in the age ordering shows in the same cycle as the read. It appears as a wrong action choice or as forwarded data from an older store to the same address. Holding-mode faults appear when a read stays held after its matching entry has drained.

// File: rtl/wrbuf_pkg.sv
package wrbuf_pkg;

    localparam int AW = 16;
    localparam int DW = 32;

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } wb_entry_t;

    typedef enum logic [1:0] {
        RD_IDLE = 2'd0,
        RD_MEM  = 2'd1,
        RD_FWD  = 2'd2,
        RD_HOLD = 2'd3
    } rd_act_e;

    // next slot index with wrap at depth d
    function automatic int wrap_next(int p, int d);
        return (p + 1 >= d) ? 0 : p + 1;
    endfunction

    // position of slot s counted from head h, ring of size d
    function automatic int slot_age(int s, int h, int d);
        return (s >= h) ? s - h : s + d - h;
    endfunction

endpackage

// File: rtl/wrbuf_fifo.sv
module wrbuf_fifo
    import wrbuf_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  wb_entry_t        push_ent,
    input  logic             pop,
    output wb_entry_t        slots    [DEPTH],
    output logic [DEPTH-1:0] slot_vld,
    output logic [PTR_W-1:0] head_ptr,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty
);

    wb_entry_t        ram [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [CNT_W-1:0] occ;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            occ    <= '0;
        end else begin
            if (push) begin
                ram[wr_ptr] <= push_ent;
                wr_ptr      <= PTR_W'(wrap_next(int'(wr_ptr), DEPTH));
            end
            if (pop) begin
                rd_ptr <= PTR_W'(wrap_next(int'(rd_ptr), DEPTH));
            end
            case ({push, pop})
                2'b10:   occ <= occ + 1'b1;
                2'b01:   occ <= occ - 1'b1;
                default: occ <= occ;
            endcase
        end
    end

    always_comb begin
        for (int g = 0; g < DEPTH; g++) begin
            slot_vld[g] = slot_age(g, int'(rd_ptr), DEPTH) < int'(occ);
        end
    end

    assign slots    = ram;
    assign head_ptr = rd_ptr;
    assign count    = occ;
    assign full     = (occ == CNT_W'(DEPTH));
    assign empty    = (occ == '0);

endmodule

// File: rtl/wrbuf_match.sv
module wrbuf_match
    import wrbuf_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  wb_entry_t        slots    [DEPTH],
    input  logic [DEPTH-1:0] slot_vld,
    input  logic [PTR_W-1:0] head_ptr,
    input  logic [AW-1:0]    rd_addr,
    output logic             hit,
    output logic [DW-1:0]    hit_data
);

    logic [DEPTH-1:0] eq;

    // one comparator per slot, all in parallel
    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign eq[g] = slot_vld[g] && (slots[g].addr == rd_addr);
    end

    // walk from oldest to youngest; the last match wins
    always_comb begin
        hit      = 1'b0;
        hit_data = '0;
        for (int i = 0; i < DEPTH; i++) begin
            int s;
            s = int'(head_ptr) + i;
            if (s >= DEPTH) s = s - DEPTH;
            if (eq[s]) begin
                hit      = 1'b1;
                hit_data = slots[s].data;
            end
        end
    end

endmodule

// File: rtl/wrbuf_rdprio.sv
module wrbuf_rdprio
    import wrbuf_pkg::*;
#(
    parameter int DEPTH  = 4,
    parameter bit FWD_EN = 1'b1,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          st_valid,
    input  logic [AW-1:0] st_addr,
    input  logic [DW-1:0] st_data,
    output logic          st_ready,
    input  logic          vic_valid,
    input  logic [AW-1:0] vic_addr,
    input  logic [DW-1:0] vic_data,
    output logic          vic_ready,
    input  logic          rd_valid,
    input  logic [AW-1:0] rd_addr,
    output logic          rd_mem_go,
    output logic          rd_fwd,
    output logic [DW-1:0] rd_fwd_data,
    output logic          rd_hold,
    output logic          mem_wr_valid,
    output logic [AW-1:0] mem_wr_addr,
    output logic [DW-1:0] mem_wr_data,
    input  logic          mem_wr_ready
);

    wb_entry_t        slots [DEPTH];
    logic [DEPTH-1:0] slot_vld;
    logic [PTR_W-1:0] head_ptr;
    logic [CNT_W-1:0] occ;
    logic             full;
    logic             empty;
    logic             push;
    logic             pop;
    wb_entry_t        push_ent;
    logic             hit;
    logic [DW-1:0]    hit_data;
    rd_act_e          act;

    // eviction port wins the single enqueue slot per cycle
    assign push     = (vic_valid || st_valid) && !full;
    assign push_ent = vic_valid ? '{addr: vic_addr, data: vic_data}
                                : '{addr: st_addr,  data: st_data};
    assign vic_ready = !full;
    assign st_ready  = !full && !vic_valid;

    wrbuf_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk      (clk),
        .rst      (rst),
        .push     (push),
        .push_ent (push_ent),
        .pop      (pop),
        .slots    (slots),
        .slot_vld (slot_vld),
        .head_ptr (head_ptr),
        .count    (occ),
        .full     (full),
        .empty    (empty)
    );

    wrbuf_match #(.DEPTH(DEPTH)) u_match (
        .slots    (slots),
        .slot_vld (slot_vld),
        .head_ptr (head_ptr),
        .rd_addr  (rd_addr),
        .hit      (hit),
        .hit_data (hit_data)
    );

    always_comb begin
        if (!rd_valid)   act = RD_IDLE;
        else if (!hit)   act = RD_MEM;
        else if (FWD_EN) act = RD_FWD;
        else             act = RD_HOLD;
    end

    assign rd_mem_go   = (act == RD_MEM);
    assign rd_fwd      = (act == RD_FWD);
    assign rd_hold     = (act == RD_HOLD);
    assign rd_fwd_data = rd_fwd ? hit_data : '0;

    // a read cleared to memory takes the memory port this cycle
    assign mem_wr_valid = !empty && !rd_mem_go;
    assign mem_wr_addr  = slots[head_ptr].addr;
    assign mem_wr_data  = slots[head_ptr].data;
    assign pop          = mem_wr_valid && mem_wr_ready;

endmodule

// File: rtl/wrbuf_chk.sv
module wrbuf_chk #(
    parameter int DEPTH = 4,
    parameter int CNT_W = 3,
    parameter int AW = 16,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          st_valid,
    input logic          st_ready,
    input logic          vic_valid,
    input logic          vic_ready,
    input logic          rd_valid,
    input logic          rd_mem_go,
    input logic          rd_fwd,
    input logic          rd_hold,
    input logic          mem_wr_valid,
    input logic          mem_wr_ready,
    input logic [AW-1:0] mem_wr_addr,
    input logic [DW-1:0] mem_wr_data,
    input logic [CNT_W-1:0] occ
);

    a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
        int'(occ) <= DEPTH);

    a_r3_full_blocks: assert property (@(posedge clk) disable iff (rst)
        (int'(occ) == DEPTH) |-> (!st_ready && !vic_ready));

    a_r4_push_pop_level: assert property (@(posedge clk) disable iff (rst)
        ((st_valid && st_ready || vic_valid && vic_ready) && mem_wr_valid && mem_wr_ready)
        |=> $stable(occ));

    a_r5_read_owns_mem: assert property (@(posedge clk) disable iff (rst)
        !(rd_mem_go && mem_wr_valid));

    a_r8_victim_first: assert property (@(posedge clk) disable iff (rst)
        vic_valid |-> !st_ready);

    a_r9_one_action: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> ($countones({rd_mem_go, rd_fwd, rd_hold}) == 1));

    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !rd_valid |-> ($countones({rd_mem_go, rd_fwd, rd_hold}) == 0));

    a_r10_head_steady: assert property (@(posedge clk) disable iff (rst)
        (mem_wr_valid && !mem_wr_ready) |=>
        (!mem_wr_valid || ($stable(mem_wr_addr) && $stable(mem_wr_data))));

endmodule

bind wrbuf_rdprio wrbuf_chk #(
    .DEPTH (DEPTH),
    .CNT_W (CNT_W),
    .AW    (wrbuf_pkg::AW),
    .DW    (wrbuf_pkg::DW)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .st_valid     (st_valid),
    .st_ready     (st_ready),
    .vic_valid    (vic_valid),
    .vic_ready    (vic_ready),
    .rd_valid     (rd_valid),
    .rd_mem_go    (rd_mem_go),
    .rd_fwd       (rd_fwd),
    .rd_hold      (rd_hold),
    .mem_wr_valid (mem_wr_valid),
    .mem_wr_ready (mem_wr_ready),
    .mem_wr_addr  (mem_wr_addr),
    .mem_wr_data  (mem_wr_data),
    .occ          (occ)
);

// File: tb/sim_wrbuf_rdprio.sv
`timescale 1ns/1ps
module sim_wrbuf_rdprio;

    localparam int D = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        st_valid = 0, vic_valid = 0, rd_valid = 0, mem_wr_ready = 0;
    logic [15:0] st_addr = 0, vic_addr = 0, rd_addr = 0;
    logic [31:0] st_data = 0, vic_data = 0;

    logic        a_st_rdy, a_vic_rdy, a_go, a_fwd, a_hold, a_mwv;
    logic [31:0] a_fdata, a_mwd;
    logic [15:0] a_mwa;
    logic        b_st_rdy, b_vic_rdy, b_go, b_fwd, b_hold, b_mwv;
    logic [31:0] b_fdata, b_mwd;
    logic [15:0] b_mwa;

    int checks = 0;
    int fails  = 0;
    logic [15:0] qa [$];
    logic [31:0] qd [$];

    always #2.5 clk = ~clk;

    wrbuf_rdprio #(.DEPTH(D), .FWD_EN(1'b1)) u0 (
        .clk(clk), .rst(rst),
        .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data), .st_ready(a_st_rdy),
        .vic_valid(vic_valid), .vic_addr(vic_addr), .vic_data(vic_data), .vic_ready(a_vic_rdy),
        .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_mem_go(a_go), .rd_fwd(a_fwd),
        .rd_fwd_data(a_fdata), .rd_hold(a_hold),
        .mem_wr_valid(a_mwv), .mem_wr_addr(a_mwa), .mem_wr_data(a_mwd), .mem_wr_ready(mem_wr_ready)
    );

    wrbuf_rdprio #(.DEPTH(D), .FWD_EN(1'b0)) u1 (
        .clk(clk), .rst(rst),
        .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data), .st_ready(b_st_rdy),
        .vic_valid(vic_valid), .vic_addr(vic_addr), .vic_data(vic_data), .vic_ready(b_vic_rdy),
        .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_mem_go(b_go), .rd_fwd(b_fwd),
        .rd_fwd_data(b_fdata), .rd_hold(b_hold),
        .mem_wr_valid(b_mwv), .mem_wr_addr(b_mwa), .mem_wr_data(b_mwd), .mem_wr_ready(mem_wr_ready)
    );

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mkdata(logic [15:0] a, int salt);
        return {a ^ 16'h5a5a, 16'(a + 16'(salt * 37))};
    endfunction

    // one cycle of enqueue and/or drain, no read; checks port view before the edge
    task automatic step(logic sv, logic [15:0] sa, logic [31:0] sd,
                        logic vv, logic [15:0] va, logic [31:0] vd, logic mr);
        bit full_now;
        @(negedge clk);
        st_valid = sv; st_addr = sa; st_data = sd;
        vic_valid = vv; vic_addr = va; vic_data = vd;
        rd_valid = 0; mem_wr_ready = mr;
        #1;
        full_now = (qa.size() == D);
        chk("R3 st_ready", {a_st_rdy, b_st_rdy}, {2{!full_now && !vv}});
        chk("R3 vic_ready", {a_vic_rdy, b_vic_rdy}, {2{!full_now}});
        if (vv) chk("R8 st_ready low with eviction", a_st_rdy, 1'b0);
        chk("R2 mem_wr_valid", {a_mwv, b_mwv}, {2{qa.size() > 0}});
        if (qa.size() > 0) begin
            chk("R2 head addr", {a_mwa, b_mwa}, {qa[0], qa[0]});
            chk("R2 head data", {a_mwd, b_mwd}, {qd[0], qd[0]});
        end
        @(posedge clk);
        if (mr && qa.size() > 0) begin
            void'(qa.pop_front());
            void'(qd.pop_front());
        end
        if (!full_now && vv) begin
            qa.push_back(va); qd.push_back(vd);
        end else if (!full_now && sv) begin
            qa.push_back(sa); qd.push_back(sd);
        end
    endtask

    task automatic push(logic [15:0] a, logic [31:0] d);
        step(1'b1, a, d, 1'b0, 16'h0, 32'h0, 1'b0);
    endtask

    task automatic drain();
        step(1'b0, 16'h0, 32'h0, 1'b0, 16'h0, 32'h0, 1'b1);
    endtask

    // read lookup on both variants
    task automatic probe(logic [15:0] a, logic mr);
        int yi;
        @(negedge clk);
        st_valid = 0; vic_valid = 0;
        rd_valid = 1; rd_addr = a; mem_wr_ready = mr;
        #1;
        yi = -1;
        foreach (qa[i]) if (qa[i] == a) yi = i;
        if (yi < 0) begin
            chk("R5 miss go", {a_go, a_fwd, a_hold, b_go, b_fwd, b_hold}, 6'b100100);
            chk("R5 drain paused", {a_mwv, b_mwv}, 2'b00);
        end else begin
            chk("R6 fwd action", {a_go, a_fwd, a_hold}, 3'b010);
            chk("R6 youngest data", a_fdata, qd[yi]);
            chk("R7 hold action", {b_go, b_fwd, b_hold}, 3'b001);
            chk("R7 drain continues", {a_mwv, b_mwv}, 2'b11);
        end
        @(posedge clk);
        if (yi >= 0 && mr) begin
            void'(qa.pop_front());
            void'(qd.pop_front());
        end
        @(negedge clk);
        rd_valid = 0; mem_wr_ready = 0;
        #1;
        chk("R9 idle quiet", {a_go, a_fwd, a_hold, b_go, b_fwd, b_hold}, 6'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        #1;
        // R1 reset state
        chk("R1 mem_wr_valid", {a_mwv, b_mwv}, 2'b00);
        chk("R1 ready", {a_st_rdy, a_vic_rdy, b_st_rdy, b_vic_rdy}, 4'hf);
        probe(16'h1234, 1'b0);

        // R2 R5 R6 sweep over every fill level
        for (int n = 1; n <= D; n++) begin
            for (int k = 0; k < n; k++) push(16'(16'h0100 * n + k), mkdata(16'(16'h0100 * n + k), n));
            probe(16'hbeef, 1'b1);
            for (int k = 0; k < n; k++) probe(16'(16'h0100 * n + k), 1'b0);
            for (int k = 0; k < n; k++) drain();
            drain();
        end

        // R3 overflow attempt then full drain
        for (int k = 0; k < D + 2; k++) push(16'(16'h0a00 + k), mkdata(16'(16'h0a00 + k), 7));
        chk("R3 queued count", qa.size(), D);
        for (int k = 0; k < D + 1; k++) drain();

        // R6 youngest of several same-address entries
        push(16'h00aa, 32'h11111111);
        push(16'h00bb, 32'h22222222);
        push(16'h00aa, 32'h33333333);
        probe(16'h00aa, 1'b0);
        probe(16'h00bb, 1'b0);
        for (int k = 0; k < 4; k++) drain();

        // R4 simultaneous enqueue and drain
        for (int k = 0; k < 3; k++) push(16'(16'h0c00 + k), mkdata(16'(16'h0c00 + k), 3));
        step(1'b1, 16'h0cff, 32'hcafe0001, 1'b0, 16'h0, 32'h0, 1'b1);
        chk("R4 level unchanged", qa.size(), 3);
        push(16'h0cfe, 32'hcafe0002);
        push(16'h0cfd, 32'hcafe0003);
        for (int k = 0; k < 5; k++) drain();

        // R8 eviction beats store in the same cycle
        step(1'b1, 16'h0d01, 32'h0d0d0d01, 1'b1, 16'h0e01, 32'h0e0e0e01, 1'b0);
        chk("R8 only eviction queued", qa.size(), 1);
        probe(16'h0d01, 1'b0);
        drain(); drain();

        // R7 held read released once the conflict drains
        push(16'h0f01, 32'hf0f0f001);
        push(16'h0f02, 32'hf0f0f002);
        probe(16'h0f01, 1'b1);
        probe(16'h0f01, 1'b0);
        probe(16'h0f02, 1'b1);
        probe(16'h0f02, 1'b0);

        // R10 head holds while memory stalls
        push(16'h0f10, 32'h0000f010);
        push(16'h0f11, 32'h0000f011);
        for (int k = 0; k < 3; k++) step(1'b0, 16'h0, 32'h0, 1'b0, 16'h0, 32'h0, 1'b0);
        chk("R10 head held", a_mwa, 16'h0f10);
        drain(); drain(); drain();

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule